// File: doc/BRIEF.md
# Quarter-Rate Quadrature-to-Real Upconverter

This block turns a stream of complex baseband samples (in-phase and quadrature, signed 16-bit) into a single real sample stream. The result is frequency-shifted by one quarter of the sample rate, either upward or downward. At a quarter of the sample rate the oscillator only takes the values 0, +1 and -1. Each output is therefore one of the two inputs, passed through or negated, and no multiplier is needed. A four-state phase sequencer selects what each sample does.

The in-phase leg produces the even-phase outputs and the quadrature leg produces the odd-phase outputs. A multiplexer alternates between the two legs, and a saturating gain stage follows it. The gain stage applies unity gain in the plain decimation mode and a gain of two in every other mode. A resynchronisation input forces the oscillator back to its zero-degree phase, so a chosen sample can be aligned with it.

The phase sequencer has four states, PH_0 to PH_3, and three transitions:
- ADVANCE: a valid sample moves the sequencer to the state after the one that sample used.
- RESYNC: sync without a valid sample returns the sequencer to PH_0.
- HOLD: no valid sample and no sync leaves the state unchanged.

Top module: `qmix_fs4_upconv`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0 and the sequencer is in PH_0. The first valid sample after reset uses phase 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `out_data` updates one clock after each valid sample and holds its value in every other cycle.
- R3: The sequencer steps PH_0→PH_1→PH_2→PH_3→PH_0, one step per valid sample (ADVANCE). Without a valid sample or sync it does not move (HOLD).
- R4: With `shift_up`=1 (upward shift, input appears as upper sideband), phases 0,1,2,3 output i, -q, -i, +q.
- R5: With `shift_up`=0 (downward shift, input appears as lower sideband), phases 0,1,2,3 output i, +q, -i, -q.
- R6: A valid sample presented with `sync`=1 is processed at phase 0, whatever the current state, and the next valid sample uses phase 1.
- R7: `sync`=1 with `in_valid`=0 returns the sequencer to PH_0 (RESYNC), so the next valid sample uses phase 0.
- R8: `mode`=2'b00 gives gain 1. `mode`=2'b01, 2'b10 and 2'b11 give gain 2. `mode` and `shift_up` are applied per sample.
- R9: Results outside the signed 16-bit range clip to 32767 or -32768. For example, negating -32768 gives 32767, and doubling ±20000 gives 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| shift_up | input | 1 | 1: shift upward by fs/4; 0: shift downward by fs/4 |
| mode | input | 2 | Gain mode: 00 gives unity gain, any other value gives gain two |
| sync | input | 1 | Forces the oscillator to phase 0 |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Real output sample, signed |

## Verification
The properties assume that `in_valid`, `sync`, `shift_up`, `mode` and both samples are driven to known values on every clock after reset is released. They also assume that `in_valid` is low while reset is applied. The gain and saturation properties only check samples that carry `sync`, because the phase of those samples is known without tracking history. The stimulus changes inputs only on the falling edge and holds `in_valid` low during every reset. Several table rows carry `sync` with both gain settings, including a full-scale negative value with gain two, so those properties are exercised.

// File: rtl/qmix_fs4_pkg.sv
package qmix_fs4_pkg;
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    localparam logic [1:0] MODE_UNITY = 2'b00;

    function automatic phase_e phase_succ(input phase_e p);
        unique case (p)
            PH_0: return PH_1;
            PH_1: return PH_2;
            PH_2: return PH_3;
            PH_3: return PH_0;
        endcase
    endfunction
endpackage

// File: rtl/qmix_fs4_phase_fsm.sv
module qmix_fs4_phase_fsm
    import qmix_fs4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  logic   sync,
    output phase_e cur_ph,
    output phase_e state_q
);
    phase_e state_d;

    // phase used by the sample presented this cycle
    always_comb begin
        cur_ph = sync ? PH_0 : state_q;
    end

    // transitions: ADVANCE, RESYNC, HOLD
    always_comb begin
        if (adv) begin
            state_d = phase_succ(cur_ph);
        end else if (sync) begin
            state_d = PH_0;
        end else begin
            state_d = state_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/qmix_fs4_leg.sv
module qmix_fs4_leg
    import qmix_fs4_pkg::*;
#(
    parameter int W    = 16,
    parameter bit IS_Q = 1'b0
) (
    input  logic signed [W-1:0] x,
    input  phase_e              ph,
    input  logic                up,
    output logic signed [W:0]   term
);
    logic signed [W:0] pos;
    logic signed [W:0] neg;

    always_comb begin
        pos = {x[W-1], x};
        neg = -pos;
    end

    generate
        if (IS_Q) begin : g_qleg
            always_comb begin
                unique case (ph)
                    PH_1:    term = up ? neg : pos;
                    PH_3:    term = up ? pos : neg;
                    default: term = '0;
                endcase
            end
        end else begin : g_ileg
            always_comb begin
                unique case (ph)
                    PH_0:    term = pos;
                    PH_2:    term = neg;
                    default: term = '0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/qmix_fs4_satgain.sv
module qmix_fs4_satgain #(
    parameter int W = 16
) (
    input  logic signed [W:0]   x,
    input  logic                dbl,
    output logic signed [W-1:0] y
);
    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] HI = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] LO = {3'b111, {(W-1){1'b0}}};

    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] scaled;

    always_comb begin
        ext    = {x[W], x};
        scaled = dbl ? (ext <<< 1) : ext;
        if (scaled > HI) begin
            y = HI[W-1:0];
        end else if (scaled < LO) begin
            y = LO[W-1:0];
        end else begin
            y = scaled[W-1:0];
        end
    end
endmodule

// File: rtl/qmix_fs4_upconv.sv
module qmix_fs4_upconv
    import qmix_fs4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic                shift_up,
    input  logic [1:0]          mode,
    input  logic                sync,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    phase_e            cur_ph;
    phase_e            state_q;
    logic [1:0]        phase_q;
    logic signed [W:0] term_i;
    logic signed [W:0] term_q;
    logic signed [W:0] merged;
    logic signed [W-1:0] scaled;
    logic              dbl;

    qmix_fs4_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid),
        .sync    (sync),
        .cur_ph  (cur_ph),
        .state_q (state_q)
    );

    qmix_fs4_leg #(.W(W), .IS_Q(1'b0)) u_leg_i (
        .x    (in_i),
        .ph   (cur_ph),
        .up   (shift_up),
        .term (term_i)
    );

    qmix_fs4_leg #(.W(W), .IS_Q(1'b1)) u_leg_q (
        .x    (in_q),
        .ph   (cur_ph),
        .up   (shift_up),
        .term (term_q)
    );

    // even phases come from the in-phase leg, odd phases from the quadrature leg
    always_comb begin
        phase_q = state_q;
        merged  = cur_ph[0] ? term_q : term_i;
        dbl     = (mode != MODE_UNITY);
    end

    qmix_fs4_satgain #(.W(W)) u_gain (
        .x   (merged),
        .dbl (dbl),
        .y   (scaled)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= scaled;
            end
        end
    end
endmodule

// File: rtl/qmix_fs4_upconv_chk.sv
module qmix_fs4_upconv_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] in_i,
    input logic                sync,
    input logic [1:0]          mode,
    input logic                out_valid,
    input logic signed [W-1:0] out_data,
    input logic [1:0]          phase_q
);
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sync) |=> (phase_q == 2'($past(phase_q) + 2'd1)));
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !sync) |=> $stable(phase_q));
    assert_sync_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sync) |=> (phase_q == 2'd1));
    assert_sync_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && sync) |=> (phase_q == 2'd0));
    assert_unity_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sync && mode == 2'b00) |=> (out_data == $past(in_i)));
    assert_clip_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sync && mode != 2'b00 && in_i == MINV) |=> (out_data == MINV));
endmodule

bind qmix_fs4_upconv qmix_fs4_upconv_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .sync      (sync),
    .mode      (mode),
    .out_valid (out_valid),
    .out_data  (out_data),
    .phase_q   (phase_q)
);

// File: tb/qmix_fs4_upconv_bench.sv
module qmix_fs4_upconv_bench;
    localparam int W = 16;
    localparam int NV = 21;
    // {valid, sync, up, mode[1:0], i, q, exp_valid, exp_data}
    localparam int VW = 5 + 3 * W + 1;

    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        {1'b1,1'b1,1'b1,2'b00, 16'sd100,  16'sd200,   1'b1, 16'sd100},   // R6 R4 ph0
        {1'b1,1'b0,1'b1,2'b00, 16'sd100,  16'sd200,   1'b1, -16'sd200},  // R4 ph1
        {1'b1,1'b0,1'b1,2'b00, 16'sd100,  16'sd200,   1'b1, -16'sd100},  // R4 ph2
        {1'b1,1'b0,1'b1,2'b00, 16'sd100,  16'sd200,   1'b1, 16'sd200},   // R4 ph3
        {1'b1,1'b0,1'b1,2'b00, 16'sd7,    16'sd9,     1'b1, 16'sd7},     // R3 wrap
        {1'b0,1'b0,1'b1,2'b00, 16'sd5,    16'sd5,     1'b0, 16'sd7},     // R2 hold
        {1'b1,1'b0,1'b0,2'b00, 16'sd300, -16'sd50,    1'b1, -16'sd50},   // R5 ph1
        {1'b1,1'b0,1'b0,2'b00, 16'sd300, -16'sd50,    1'b1, -16'sd300},  // R5 ph2
        {1'b1,1'b0,1'b0,2'b00, 16'sd300, -16'sd50,    1'b1, 16'sd50},    // R5 ph3
        {1'b1,1'b0,1'b0,2'b01, 16'sd300, -16'sd50,    1'b1, 16'sd600},   // R8 ph0
        {1'b1,1'b0,1'b1,2'b10, 16'sd300, -16'sd50,    1'b1, 16'sd100},   // R8 ph1
        {1'b1,1'b1,1'b1,2'b11, 16'sd1000, 16'sd3,     1'b1, 16'sd2000},  // R6 R8
        {1'b1,1'b0,1'b1,2'b11, 16'sd1000, 16'sd3,     1'b1, -16'sd6},    // R6 ph1
        {1'b0,1'b1,1'b1,2'b00, 16'sd0,    16'sd0,     1'b0, -16'sd6},    // R7 idle sync
        {1'b1,1'b0,1'b1,2'b00,-16'sd32768,16'sd1,     1'b1, -16'sd32768},// R7 ph0
        {1'b1,1'b0,1'b1,2'b00, 16'sd0,   -16'sd32768, 1'b1, 16'sd32767}, // R9 neg min
        {1'b1,1'b0,1'b1,2'b01, 16'sd20000,16'sd0,     1'b1, -16'sd32768},// R9 ph2
        {1'b1,1'b0,1'b1,2'b01, 16'sd0,    16'sd20000, 1'b1, 16'sd32767}, // R9 ph3
        {1'b1,1'b1,1'b1,2'b10,-16'sd32768,16'sd0,     1'b1, -16'sd32768},// R9 sync
        {1'b1,1'b0,1'b0,2'b00, 16'sd4,    16'sd11,    1'b1, 16'sd11},    // R5 ph1
        {1'b0,1'b0,1'b0,2'b00, 16'sd0,    16'sd0,     1'b0, 16'sd11}     // R3 hold
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_i = '0;
    logic signed [W-1:0] in_q = '0;
    logic                shift_up = 1'b0;
    logic [1:0]          mode = 2'b00;
    logic                sync = 1'b0;
    logic                out_valid;
    logic signed [W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    qmix_fs4_upconv #(.W(W)) u_qmix_fs4_upconv (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .shift_up  (shift_up),
        .mode      (mode),
        .sync      (sync),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string req, input logic ev, input logic signed [W-1:0] ed);
        n_chk++;
        if (out_valid !== ev || out_data !== ed) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b data=%0d, expected valid=%0b data=%0d",
                     req, out_valid, out_data, ev, ed);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic up,
                         input logic [1:0] m, input logic signed [W-1:0] i,
                         input logic signed [W-1:0] q);
        @(negedge clk);
        in_valid = v; sync = s; shift_up = up; mode = m; in_i = i; in_q = q;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] e;
            e = VEC[k];
            drive(e[VW-1], e[VW-2], e[VW-3], e[VW-4 -: 2],
                  e[VW-6 -: W], e[VW-6-W -: W]);
            check($sformatf("vector %0d", k), e[W], e[W-1:0]);
        end

        // R1: reset mid-stream clears outputs and sequencer
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'sd9, 16'sd8);   // advances to a nonzero phase
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 async clear", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'sd55, 16'sd66);
        check("R1 phase0 after reset", 1'b1, 16'sd55);
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'sd55, 16'sd66);
        check("R4 phase1 after reset", 1'b1, -16'sd66);
        drive(1'b0, 1'b0, 1'b1, 2'b00, 16'sd0, 16'sd0);
        check("R2 drop valid", 1'b0, -16'sd66);
        drive(1'b1, 1'b0, 1'b1, 2'b01, -16'sd20000, 16'sd0);
        check("R9 clip high on phase2", 1'b1, 16'sd32767);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule